// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a register-mapped master for the two-wire PHY management bus. Software composes a complete 32-bit management frame word (start bits, opcode, PHY address, register number, turnaround bits and, for writes, 16 data bits) and stores it into the frame register. That store starts a transfer. The block sends 32 preamble ones and then the frame word, most significant bit first, on the management data line. It generates the management clock from the system clock through a programmable divider. On a read frame it releases the data line from the turnaround bits onward and shifts in the 16 bits the PHY returns. When the transfer ends it writes those bits back into the low half of the frame register.

Completion sets a write-one-to-clear event bit. An event mask bit routes that event to an interrupt output. With the mask at zero, software polls the event bit instead. A self-clearing bit in the control register resets the whole block, including its registers and any transfer in progress.

The engine is a four-state machine. `ST_IDLE` moves to `ST_PREAMBLE` when the frame register is written. `ST_PREAMBLE` moves to `ST_FRAME` on the falling clock edge that ends preamble bit 31. `ST_FRAME` moves to `ST_FINISH` on the falling edge that ends frame bit 31. `ST_FINISH` always returns to `ST_IDLE` after one cycle. A soft reset sends any state to `ST_IDLE`.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, `mdc`, `mdio_oe` and `irq` are 0, and every register reads back as zero.
- R2: A write to the frame register (address 3) while idle starts a transfer. `mdio_oe` goes high with `mdio_out` at 1 for 32 management clock periods of preamble.
- R3: After the preamble, the 32 frame bits are driven MSB first. `mdio_out` changes only on a falling management clock edge and holds steady while `mdc` is high.
- R4: A read frame is one with bits 29:28 equal to 2'b10. For a read, `mdio_oe` is released from frame bit 17 (the first turnaround bit) to the end of the frame. Data bits 15:0 are sampled MSB first on rising clock edges. At completion they replace frame register bits 15:0, and bits 31:16 are kept.
- R5: Any frame that is not a read keeps `mdio_oe` high through the last frame bit and leaves the frame register unchanged.
- R6: Completion sets event register (address 1) bit 0. Writing 1 to that bit clears it, and writing 0 leaves it set.
- R7: `irq` is high exactly when event bit 0 and mask register (address 2) bit 0 are both 1. With the mask at 0, completion never raises `irq`.
- R8: The speed register (address 4) holds the divider value d in bits 6:1. `mdc` spends d system clocks high and d clocks low.
- R9: A divider value of 0 holds `mdc` low and stalls the transfer. Writing a nonzero value lets the transfer continue to completion.
- R10: A frame register write while a transfer is in progress is ignored. The register readback and the transfer in progress are unchanged.
- R11: Writing 1 to control register (address 0) bit 0 makes that bit read 1 for one cycle. On the next cycle the block resets: the transfer is aborted, all registers are zero and the bit reads 0.
- R12: A read with `mdio_in` held high by the bus pull-up (no PHY responding) returns 0xFFFF in frame bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_write | input | 1 | Access is a write when high |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on `bus_addr` |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_in | input | 1 | Management data in |
| irq | output | 1 | Masked completion interrupt |

## Verification
Three situations are hard to reach from the ports: a frame write landing while a transfer is in progress, a divider of zero that freezes a transfer in its preamble, and a soft reset that cuts into an active frame. The stimulus starts a transfer and waits a fixed number of cycles into it before issuing the competing access. It programs the divider to zero before starting a frame and releases it later. A behavioural reference model tracks bit position and clock phase, and it acts as the PHY, so every clock compares the pins against the model's expected values.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_FRAME,
        ST_FINISH
    } mdio_state_e;

    localparam int REG_CTRL  = 0;
    localparam int REG_EVENT = 1;
    localparam int REG_MASK  = 2;
    localparam int REG_FRAME = 3;
    localparam int REG_SPEED = 4;

    localparam logic [1:0] OP_READ = 2'b10;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             hit;

    assign hit  = run && (div != '0) &&
                  (({1'b0, cnt_q} + (DIV_W+1)'(1)) >= {1'b0, div});
    assign rise = hit && !mdc_q;
    assign fall = hit && mdc_q;
    assign mdc  = mdc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (srst || !run || div == '0) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (hit) begin
            cnt_q <= '0;
            mdc_q <= !mdc_q;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // R9: a zero divider forces the clock low on the next cycle
    assert_mdc_low_div0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0) |=> !mdc_q);

endmodule

// File: rtl/mdio_engine.sv
module mdio_engine import mdio_pkg::*; #(
    parameter int FRAME_W = 32,
    parameter int PRE_LEN = 32,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               srst,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               rise,
    input  logic               fall,
    input  logic               mdio_in,
    output logic               run,
    output logic               busy,
    output logic               done,
    output logic               is_rd,
    output logic [DATA_W-1:0]  rx_data,
    output logic               mdio_out,
    output logic               mdio_oe
);
    localparam int MAXLEN = (FRAME_W > PRE_LEN) ? FRAME_W : PRE_LEN;
    localparam int CW     = $clog2(MAXLEN);
    localparam int TA_POS = FRAME_W - DATA_W - 2;
    localparam int RX_POS = FRAME_W - DATA_W;

    mdio_state_e        state_q, state_d;
    logic [CW-1:0]      idx_q;
    logic [FRAME_W-1:0] sh_q;
    logic [DATA_W-1:0]  rx_q;
    logic               rd_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (fall && idx_q == CW'(PRE_LEN-1)) state_d = ST_FRAME;
            ST_FRAME:    if (fall && idx_q == CW'(FRAME_W-1)) state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state_q <= ST_IDLE;
        else if (srst) state_q <= ST_IDLE;
        else           state_q <= state_d;
    end

    // bit position, shift data, capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            sh_q  <= '0;
            rx_q  <= '0;
            rd_q  <= 1'b0;
        end else if (srst) begin
            idx_q <= '0;
            sh_q  <= '0;
            rx_q  <= '0;
            rd_q  <= 1'b0;
        end else if (state_q == ST_IDLE && start) begin
            idx_q <= '0;
            sh_q  <= frame_in;
            rx_q  <= '0;
            rd_q  <= (frame_in[FRAME_W-3:FRAME_W-4] == OP_READ);
        end else begin
            if (fall && state_q == ST_PREAMBLE)
                idx_q <= (idx_q == CW'(PRE_LEN-1)) ? '0 : idx_q + CW'(1);
            if (fall && state_q == ST_FRAME) begin
                idx_q <= (idx_q == CW'(FRAME_W-1)) ? '0 : idx_q + CW'(1);
                sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
            end
            if (rise && state_q == ST_FRAME && idx_q >= CW'(RX_POS))
                rx_q <= {rx_q[DATA_W-2:0], mdio_in};
        end
    end

    // outputs
    always_comb begin
        run      = (state_q == ST_PREAMBLE) || (state_q == ST_FRAME);
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_FINISH);
        is_rd    = rd_q;
        rx_data  = rx_q;
        mdio_out = (state_q == ST_FRAME) ? sh_q[FRAME_W-1] : 1'b1;
        mdio_oe  = (state_q == ST_PREAMBLE) ||
                   ((state_q == ST_FRAME) && !(rd_q && idx_q >= CW'(TA_POS)));
    end

    // R4: a read ends with the line released
    assert_rd_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rd_q) |-> !$past(mdio_oe));
    // R5: a write keeps driving through its last bit
    assert_wr_driven_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rd_q) |-> $past(mdio_oe));

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master import mdio_pkg::*; #(
    parameter int FRAME_W = 32,
    parameter int PRE_LEN = 32,
    parameter int DATA_W  = 16,
    parameter int DIV_W   = 6,
    parameter int ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [FRAME_W-1:0] bus_wdata,
    output logic [FRAME_W-1:0] bus_rdata,
    output logic               mdc,
    output logic               mdio_out,
    output logic               mdio_oe,
    input  logic               mdio_in,
    output logic               irq
);
    logic               wr;
    logic               rst_pend_q;
    logic               srst;
    logic               event_q;
    logic               mask_q;
    logic [DIV_W-1:0]   div_q;
    logic [FRAME_W-1:0] frame_q;
    logic               start;
    logic               run, busy, done, is_rd;
    logic               rise, fall;
    logic [DATA_W-1:0]  rx_data;

    assign wr    = bus_sel && bus_write;
    assign srst  = rst_pend_q;
    assign start = wr && (bus_addr == ADDR_W'(REG_FRAME)) && !busy && !srst;
    assign irq   = event_q && mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_pend_q <= 1'b0;
            event_q    <= 1'b0;
            mask_q     <= 1'b0;
            div_q      <= '0;
            frame_q    <= '0;
        end else if (srst) begin
            rst_pend_q <= 1'b0;
            event_q    <= 1'b0;
            mask_q     <= 1'b0;
            div_q      <= '0;
            frame_q    <= '0;
        end else begin
            if (wr && bus_addr == ADDR_W'(REG_CTRL) && bus_wdata[0])
                rst_pend_q <= 1'b1;
            if (done)
                event_q <= 1'b1;
            else if (wr && bus_addr == ADDR_W'(REG_EVENT) && bus_wdata[0])
                event_q <= 1'b0;
            if (wr && bus_addr == ADDR_W'(REG_MASK))
                mask_q <= bus_wdata[0];
            if (wr && bus_addr == ADDR_W'(REG_SPEED))
                div_q <= bus_wdata[DIV_W:1];
            if (start)
                frame_q <= bus_wdata;
            else if (done && is_rd)
                frame_q[DATA_W-1:0] <= rx_data;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(REG_CTRL):  bus_rdata[0] = rst_pend_q;
            ADDR_W'(REG_EVENT): bus_rdata[0] = event_q;
            ADDR_W'(REG_MASK):  bus_rdata[0] = mask_q;
            ADDR_W'(REG_FRAME): bus_rdata = frame_q;
            ADDR_W'(REG_SPEED): bus_rdata[DIV_W:1] = div_q;
            default:            bus_rdata = '0;
        endcase
    end

    mdio_mdc_gen #(.DIV_W(DIV_W)) i_mdc_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .srst  (srst),
        .run   (run),
        .div   (div_q),
        .mdc   (mdc),
        .rise  (rise),
        .fall  (fall)
    );

    mdio_engine #(.FRAME_W(FRAME_W), .PRE_LEN(PRE_LEN), .DATA_W(DATA_W)) i_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (srst),
        .start    (start),
        .frame_in (bus_wdata),
        .rise     (rise),
        .fall     (fall),
        .mdio_in  (mdio_in),
        .run      (run),
        .busy     (busy),
        .done     (done),
        .is_rd    (is_rd),
        .rx_data  (rx_data),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe)
    );

    // R3: data line holds while the clock is high
    assert_out_steady_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> $stable(mdio_out));
    // R6: completion leaves the event set
    assert_done_sets_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> event_q);
    // R10: busy frame write leaves the frame register alone
    assert_busy_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'(REG_FRAME) && busy && !done && !srst) |=> $stable(frame_q));
    // R11: soft reset clears state and registers
    assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!busy && !event_q && frame_q == '0 && !mdc));

endmodule

// File: tb/test_mdio_frame_master.sv
module test_mdio_frame_master;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_write = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_out, mdio_oe, mdio_in, irq;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit finished = 0;

    // behavioural reference model
    int          ph = 0, idx = 0, cnt = 0;
    bit          m_mdc = 0, m_rd = 0, m_evt = 0, m_msk = 0, m_rstp = 0;
    int          m_spd = 0;
    logic [31:0] m_frm = '0;
    logic [15:0] m_rx = '0;
    logic [15:0] phy_reply = 16'hFFFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    // PHY: drives the reply during the data bits, pull-up otherwise (R12)
    assign mdio_in = (ph == 2 && idx >= 16) ? phy_reply[31-idx] : 1'b1;

    mdio_frame_master i_mdio_frame_master (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in), .irq(irq)
    );

    always @(posedge clk) begin
        bit hit, rs, fl, wr;
        if (!rst_n) begin
            ph = 0; idx = 0; cnt = 0; m_mdc = 0; m_rd = 0; m_evt = 0;
            m_msk = 0; m_rstp = 0; m_spd = 0; m_frm = '0; m_rx = '0;
        end else if (m_rstp) begin
            ph = 0; idx = 0; cnt = 0; m_mdc = 0; m_rd = 0; m_evt = 0;
            m_msk = 0; m_rstp = 0; m_spd = 0; m_frm = '0; m_rx = '0;
        end else begin
            hit = (ph == 1 || ph == 2) && m_spd != 0 && (cnt + 1 >= m_spd);
            rs = hit && !m_mdc;
            fl = hit && m_mdc;
            wr = bus_sel && bus_write;
            if (!(ph == 1 || ph == 2) || m_spd == 0) begin cnt = 0; m_mdc = 0; end
            else if (hit) begin cnt = 0; m_mdc = !m_mdc; end
            else cnt++;
            if (rs && ph == 2 && idx >= 16) m_rx = {m_rx[14:0], mdio_in};
            if (ph == 3) m_evt = 1;
            else if (wr && bus_addr == 1 && bus_wdata[0]) m_evt = 0;
            if (wr && bus_addr == 0 && bus_wdata[0]) m_rstp = 1;
            if (wr && bus_addr == 2) m_msk = bus_wdata[0];
            if (wr && bus_addr == 4) m_spd = bus_wdata[6:1];
            case (ph)
                0: if (wr && bus_addr == 3) begin
                       m_frm = bus_wdata; m_rd = (bus_wdata[29:28] == 2'b10);
                       ph = 1; idx = 0; m_rx = '0;
                   end
                1: if (fl) begin if (idx == 31) begin ph = 2; idx = 0; end else idx++; end
                2: if (fl) begin if (idx == 31) begin ph = 3; idx = 0; end else idx++; end
                default: begin if (m_rd) m_frm[15:0] = m_rx; ph = 0; end
            endcase
        end
    end

    // pin comparison on every clock (R2 R3 R4 R5 R7 R8 R9)
    always @(negedge clk) begin
        bit e_oe, e_out, e_irq;
        if (rst_n) begin
            e_oe  = (ph == 1) || (ph == 2 && !(m_rd && idx >= 14));
            e_out = (ph == 2) ? m_frm[31-idx] : 1'b1;
            e_irq = m_evt && m_msk;
            n_cmp++;
            if (mdc !== m_mdc || mdio_oe !== e_oe || mdio_out !== e_out || irq !== e_irq) begin
                n_bad++;
                $display("FAIL R2 R3 R4 R5 R7 R8 R9 pins at cycle %0d: mdc/oe/out/irq actual %b%b%b%b expected %b%b%b%b",
                         cyc, mdc, mdio_oe, mdio_out, irq, m_mdc, e_oe, e_out, e_irq);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_write = 0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1 chk(req, bus_rdata, exp);
    endtask

    task automatic wait_evt(input string req);
        bit seen = 0;
        for (int k = 0; k < 3000 && !seen; k++) begin
            @(negedge clk);
            bus_addr = 3'd1;
            #1 seen = bus_rdata[0];
        end
        chk(req, 32'(seen), 32'd1);
    endtask

    function automatic logic [31:0] rd_frame(input int pa, input int ra);
        return 32'h6002_0000 | (32'(pa) << 23) | (32'(ra) << 18);
    endfunction

    initial begin
        logic [31:0] f, g;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        for (int a = 0; a < 5; a++) rd_chk(3'(a), 32'h0, "R1 register reset");
        chk("R1 pins at reset", {29'h0, mdc, mdio_oe, irq}, 32'h0);

        // R8: divider readback and MDC high time
        wr_reg(3'd4, 32'd2 << 1);
        rd_chk(3'd4, 32'h4, "R8 speed readback");

        // R4: read with PHY reply
        phy_reply = 16'hA5C3;
        f = rd_frame(5, 2);
        wr_reg(3'd3, f);
        do @(negedge clk); while (!mdc);
        n = 0;
        while (mdc) begin @(negedge clk); n++; end
        chk("R8 mdc high cycles", 32'(n), 32'd2);
        wait_evt("R6 read completion event");
        rd_chk(3'd3, f | 32'hA5C3, "R4 read data in frame");
        chk("R7 irq masked", {31'h0, irq}, 32'h0);

        // R6: write 0 keeps, write 1 clears
        wr_reg(3'd1, 32'h0);
        rd_chk(3'd1, 32'h1, "R6 write zero no effect");
        wr_reg(3'd1, 32'h1);
        rd_chk(3'd1, 32'h0, "R6 w1c clear");

        // R5: write frame
        g = 32'h5002_0000 | (32'd3 << 23) | (32'd4 << 18) | 32'hBEEF;
        wr_reg(3'd3, g);
        wait_evt("R6 write completion event");
        rd_chk(3'd3, g, "R5 write frame unchanged");
        wr_reg(3'd1, 32'hFFFF_FFFF);

        // R10: busy write ignored; R7 irq with mask
        wr_reg(3'd2, 32'h1);
        phy_reply = 16'h1234;
        f = rd_frame(1, 9);
        wr_reg(3'd3, f);
        repeat (20) @(negedge clk);
        wr_reg(3'd3, 32'h5002_FFFF);
        rd_chk(3'd3, f, "R10 busy write ignored");
        wait_evt("R10 transfer completes");
        @(negedge clk);
        chk("R7 irq on event with mask", {31'h0, irq}, 32'h1);
        rd_chk(3'd3, f | 32'h1234, "R10 first frame data kept");
        wr_reg(3'd1, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R7 irq cleared", {31'h0, irq}, 32'h0);

        // R12: no PHY
        phy_reply = 16'hFFFF;
        f = rd_frame(31, 1);
        wr_reg(3'd3, f);
        wait_evt("R12 completion");
        rd_chk(3'd3, f | 32'hFFFF, "R12 no PHY reply");
        wr_reg(3'd1, 32'h1);

        // R9: divider zero stalls
        wr_reg(3'd4, 32'h0);
        wr_reg(3'd3, g);
        repeat (100) @(negedge clk);
        rd_chk(3'd1, 32'h0, "R9 stalled no event");
        chk("R9 mdc held low", {31'h0, mdc}, 32'h0);
        wr_reg(3'd4, 32'd1 << 1);
        wait_evt("R9 resume completes");
        wr_reg(3'd1, 32'h1);

        // R11: soft reset mid-transfer
        wr_reg(3'd2, 32'h1);
        wr_reg(3'd4, 32'd3 << 1);
        wr_reg(3'd3, rd_frame(2, 3));
        repeat (50) @(negedge clk);
        wr_reg(3'd0, 32'h1);
        bus_addr = 3'd0;
        #1 chk("R11 control bit set", bus_rdata, 32'h1);
        rd_chk(3'd0, 32'h0, "R11 control self clear");
        rd_chk(3'd3, 32'h0, "R11 frame cleared");
        rd_chk(3'd4, 32'h0, "R11 speed cleared");
        rd_chk(3'd2, 32'h0, "R11 mask cleared");
        chk("R11 oe released", {31'h0, mdio_oe}, 32'h0);
        repeat (10) @(negedge clk);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule